// File: doc/BRIEF.md
# Paged Memory Chip-Select Decoder

This block turns a 24-bit CPU address into active-low chip selects for the board's memory and I/O devices. Two ROM selects cover two adjacent 512 KB windows high in the map. Three RAM selects cover two fixed 128 KB windows and an optional RAM bank of one to four 512 KB blocks. Three I/O base selects mark small windows near the top of the first 64 KB. The peripheral and option controllers use these selects to decode their own registers. A memory strobe qualifies the memory selects and an I/O strobe qualifies the I/O selects. Everything outside the listed windows selects nothing.

Two windows in the low 64 KB are remapped instead of decoded at a fixed place. The lowest 32 KB is a ROM image on the first ROM select. When an option board reports a boot ROM of its own, that image select is withheld so the board can answer. The page-0 image window above it is steered by a single control bit. When the bit is 0 the window goes to the second fixed RAM select, and when it is 1 it goes to the optional RAM bank. Reset clears the bit. Software sets it by writing through a fixed I/O address in the peripheral window.

The decode itself is combinational. The control bit is the only state.

Top module: `mem_cs_decoder`

## Requirements
- R1: `ros1N` is low for a memory access in C00000h–C7FFFFh, and `ros2N` is low for a memory access in C80000h–CFFFFFh.
- R2: `ras1N` is low for a memory access in 1C0000h–1DFFFFh, and `ras2N` is low for a memory access in 1E0000h–1FFFFFh.
- R3: `ras3N` is low for a memory access from 200000h up to 200000h + RAS3_BLOCKS × 80000h − 1. With the default RAS3_BLOCKS = 1 the bank ends at 27FFFFh, and 280000h–3FFFFFh selects nothing.
- R4: A memory access in 000000h–007FFFh drives `ros1N` low when `bootBoard` is 0, and drives no select when `bootBoard` is 1.
- R5: A memory access in 008000h–00F7FFh drives `ras2N` low when the page bit is 0 and `ras3N` low when it is 1. A memory access in 00F800h–00FFFFh selects nothing.
- R6: The asynchronous active-low `rstN` clears the page bit, so the page-0 window maps to `ras2N` right after reset.
- R7: The page bit takes `wrData` on a rising clock edge only when `ioStrobe`, `regWr` and `addr` = 00FF9Fh all hold in that cycle. The new mapping applies from the next cycle. A write at any other address, or without `ioStrobe`, leaves the bit unchanged.
- R8: With `ioStrobe` high, `perSelN` is low for 00FF80h–00FF9Fh, `opt1SelN` for 00FFC0h–00FFCFh and `opt2SelN` for 00FFD0h–00FFDFh. Every other I/O address, including 00FFA0h–00FFBFh and 00FFE0h–00FFFFh, selects nothing.
- R9: All selects are active low. Memory selects stay high unless `memStrobe` is 1, and I/O selects stay high unless `ioStrobe` is 1.
- R10: Memory addresses outside the listed windows select nothing. This includes 010000h–1BFFFFh, 400000h–BFFFFFh and D00000h–FFFFFFh.
- R11: At most one of the five memory selects is low in any cycle, and at most one of the three I/O selects is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the page control bit |
| rstN | input | 1 | Asynchronous active-low reset; clears the page bit |
| addr | input | 24 | CPU address |
| memStrobe | input | 1 | Memory bus cycle in progress |
| ioStrobe | input | 1 | I/O bus cycle in progress |
| regWr | input | 1 | Register write strobe |
| wrData | input | 1 | Data bit written into the page bit |
| bootBoard | input | 1 | Option boot board present; withholds the low ROM image |
| ros1N | output | 1 | First ROM select, active low |
| ros2N | output | 1 | Second ROM select, active low |
| ras1N | output | 1 | First fixed RAM select, active low |
| ras2N | output | 1 | Second fixed RAM select, active low |
| ras3N | output | 1 | Optional RAM bank select, active low |
| perSelN | output | 1 | Peripheral controller base select, active low |
| opt1SelN | output | 1 | First option base select, active low |
| opt2SelN | output | 1 | Second option base select, active low |

## Verification
A control-bit write and a peripheral select always fall in the same cycle, because the write address lies inside the peripheral window. The bench provokes this by sampling `perSelN` during the write cycle, before the edge. It then checks that the page-0 window moves to the other RAM select only on the following cycle. The bench also confirms that near-miss writes leave the mapping unchanged: one at the neighbouring address and one without the I/O strobe. The page window is read before and after each write and again after a fresh reset.

// File: rtl/cs_decode_pkg.sv
package cs_decode_pkg;

  localparam int ADDR_W   = 24;
  localparam int MEM_LSB  = 14;   // granule used for the large memory regions
  localparam int PAGE_LSB = 11;   // finer granule for the page-0 window edge
  localparam int IO_LSB   = 0;

  localparam logic [ADDR_W-1:0] ROM1_LO  = 24'hC00000;
  localparam logic [ADDR_W-1:0] ROM1_HI  = 24'hC7FFFF;
  localparam logic [ADDR_W-1:0] ROM2_LO  = 24'hC80000;
  localparam logic [ADDR_W-1:0] ROM2_HI  = 24'hCFFFFF;
  localparam logic [ADDR_W-1:0] RAM1_LO  = 24'h1C0000;
  localparam logic [ADDR_W-1:0] RAM1_HI  = 24'h1DFFFF;
  localparam logic [ADDR_W-1:0] RAM2_LO  = 24'h1E0000;
  localparam logic [ADDR_W-1:0] RAM2_HI  = 24'h1FFFFF;
  localparam logic [ADDR_W-1:0] RAM3_LO  = 24'h200000;
  localparam logic [ADDR_W-1:0] RAM3_BLK = 24'h080000;
  localparam logic [ADDR_W-1:0] BOOT_LO  = 24'h000000;
  localparam logic [ADDR_W-1:0] BOOT_HI  = 24'h007FFF;
  localparam logic [ADDR_W-1:0] PAGE_LO  = 24'h008000;
  localparam logic [ADDR_W-1:0] PAGE_HI  = 24'h00F7FF;
  localparam logic [ADDR_W-1:0] PER_LO   = 24'h00FF80;
  localparam logic [ADDR_W-1:0] PER_HI   = 24'h00FF9F;
  localparam logic [ADDR_W-1:0] OPT1_LO  = 24'h00FFC0;
  localparam logic [ADDR_W-1:0] OPT1_HI  = 24'h00FFCF;
  localparam logic [ADDR_W-1:0] OPT2_LO  = 24'h00FFD0;
  localparam logic [ADDR_W-1:0] OPT2_HI  = 24'h00FFDF;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 24'h00FF9F;

  // strobes handed from control to datapath
  typedef struct packed {
    logic pageToRas3;
  } ctrlStrb_t;

  // active-high memory selects
  typedef struct packed {
    logic ros1;
    logic ros2;
    logic ras1;
    logic ras2;
    logic ras3;
  } memSel_t;

  // active-high I/O base selects
  typedef struct packed {
    logic per;
    logic opt1;
    logic opt2;
  } ioSel_t;

endpackage

// File: rtl/cs_range_hit.sv
module cs_range_hit #(
  parameter int AW = 24,
  parameter int LSB = 14,
  parameter logic [AW-1:0] LO = '0,
  parameter logic [AW-1:0] HI = '1
) (
  input  logic [AW-1:LSB] addrHi,
  output logic            hit
);

  localparam int SW = AW - LSB;
  localparam logic [SW-1:0] LO_S = LO[AW-1:LSB];
  localparam logic [SW-1:0] HI_S = HI[AW-1:LSB];
  localparam bool_lo = (LO_S == '0);
  localparam bool_hi = (HI_S == '1);

  logic aboveLo;
  logic belowHi;

  generate
    if (bool_lo) begin : g_noLo
      assign aboveLo = 1'b1;
    end else begin : g_lo
      assign aboveLo = (addrHi >= LO_S);
    end
    if (bool_hi) begin : g_noHi
      assign belowHi = 1'b1;
    end else begin : g_hi
      assign belowHi = (addrHi <= HI_S);
    end
  endgenerate

  assign hit = aboveLo & belowHi;

endmodule

// File: rtl/cs_ctrl.sv
module cs_ctrl
  import cs_decode_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WR_ADDR = CTRL_ADDR
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ioStrobe,
  input  logic              regWr,
  input  logic              wrData,
  output ctrlStrb_t         ctrl
);

  logic wrHit;
  logic pageBit;

  assign wrHit = ioStrobe & regWr & (addr == WR_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageBit <= 1'b0;
    end else if (wrHit) begin
      pageBit <= wrData;
    end
  end

  always_comb begin
    ctrl = '0;
    ctrl.pageToRas3 = pageBit;
  end

endmodule

// File: rtl/cs_datapath.sv
module cs_datapath
  import cs_decode_pkg::*;
#(
  parameter int RAS3_BLOCKS = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              memStrobe,
  input  logic              ioStrobe,
  input  logic              bootBoard,
  input  ctrlStrb_t         ctrl,
  output memSel_t           memSel,
  output ioSel_t            ioSel
);

  localparam logic [ADDR_W-1:0] RAM3_HI =
    ADDR_W'(RAM3_LO + RAS3_BLOCKS * RAM3_BLK - 1);

  localparam int NUM_IO = 3;
  localparam logic [NUM_IO-1:0][ADDR_W-1:0] IO_LO_TAB = {PER_LO, OPT1_LO, OPT2_LO};
  localparam logic [NUM_IO-1:0][ADDR_W-1:0] IO_HI_TAB = {PER_HI, OPT1_HI, OPT2_HI};

  logic hitRom1, hitRom2, hitRam1, hitRam2, hitRam3, hitBoot, hitPage;
  logic [NUM_IO-1:0] ioHit;

  cs_range_hit #(.AW(ADDR_W), .LSB(MEM_LSB), .LO(ROM1_LO), .HI(ROM1_HI))
    u_rom1 (.addrHi(addr[ADDR_W-1:MEM_LSB]), .hit(hitRom1));
  cs_range_hit #(.AW(ADDR_W), .LSB(MEM_LSB), .LO(ROM2_LO), .HI(ROM2_HI))
    u_rom2 (.addrHi(addr[ADDR_W-1:MEM_LSB]), .hit(hitRom2));
  cs_range_hit #(.AW(ADDR_W), .LSB(MEM_LSB), .LO(RAM1_LO), .HI(RAM1_HI))
    u_ram1 (.addrHi(addr[ADDR_W-1:MEM_LSB]), .hit(hitRam1));
  cs_range_hit #(.AW(ADDR_W), .LSB(MEM_LSB), .LO(RAM2_LO), .HI(RAM2_HI))
    u_ram2 (.addrHi(addr[ADDR_W-1:MEM_LSB]), .hit(hitRam2));
  cs_range_hit #(.AW(ADDR_W), .LSB(MEM_LSB), .LO(RAM3_LO), .HI(RAM3_HI))
    u_ram3 (.addrHi(addr[ADDR_W-1:MEM_LSB]), .hit(hitRam3));
  cs_range_hit #(.AW(ADDR_W), .LSB(MEM_LSB), .LO(BOOT_LO), .HI(BOOT_HI))
    u_boot (.addrHi(addr[ADDR_W-1:MEM_LSB]), .hit(hitBoot));
  cs_range_hit #(.AW(ADDR_W), .LSB(PAGE_LSB), .LO(PAGE_LO), .HI(PAGE_HI))
    u_page (.addrHi(addr[ADDR_W-1:PAGE_LSB]), .hit(hitPage));

  generate
    for (genvar i = 0; i < NUM_IO; i++) begin : g_io
      cs_range_hit #(.AW(ADDR_W), .LSB(IO_LSB), .LO(IO_LO_TAB[i]), .HI(IO_HI_TAB[i]))
        u_io (.addrHi(addr), .hit(ioHit[i]));
    end
  endgenerate

  always_comb begin
    memSel = '0;
    if (memStrobe) begin
      memSel.ros1 = hitRom1 | (hitBoot & ~bootBoard);
      memSel.ros2 = hitRom2;
      memSel.ras1 = hitRam1;
      memSel.ras2 = hitRam2 | (hitPage & ~ctrl.pageToRas3);
      memSel.ras3 = hitRam3 | (hitPage &  ctrl.pageToRas3);
    end
  end

  always_comb begin
    ioSel = '0;
    if (ioStrobe) begin
      ioSel.per  = ioHit[2];
      ioSel.opt1 = ioHit[1];
      ioSel.opt2 = ioHit[0];
    end
  end

endmodule

// File: rtl/mem_cs_decoder.sv
module mem_cs_decoder
  import cs_decode_pkg::*;
#(
  parameter int RAS3_BLOCKS = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [23:0] addr,
  input  logic        memStrobe,
  input  logic        ioStrobe,
  input  logic        regWr,
  input  logic        wrData,
  input  logic        bootBoard,
  output logic        ros1N,
  output logic        ros2N,
  output logic        ras1N,
  output logic        ras2N,
  output logic        ras3N,
  output logic        perSelN,
  output logic        opt1SelN,
  output logic        opt2SelN
);

  ctrlStrb_t ctrlStrb;
  memSel_t   memSel;
  ioSel_t    ioSel;

  cs_ctrl #(.WR_ADDR(CTRL_ADDR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .ioStrobe (ioStrobe),
    .regWr    (regWr),
    .wrData   (wrData),
    .ctrl     (ctrlStrb)
  );

  cs_datapath #(.RAS3_BLOCKS(RAS3_BLOCKS)) u_dp (
    .addr      (addr),
    .memStrobe (memStrobe),
    .ioStrobe  (ioStrobe),
    .bootBoard (bootBoard),
    .ctrl      (ctrlStrb),
    .memSel    (memSel),
    .ioSel     (ioSel)
  );

  assign ros1N    = ~memSel.ros1;
  assign ros2N    = ~memSel.ros2;
  assign ras1N    = ~memSel.ras1;
  assign ras2N    = ~memSel.ras2;
  assign ras3N    = ~memSel.ras3;
  assign perSelN  = ~ioSel.per;
  assign opt1SelN = ~ioSel.opt1;
  assign opt2SelN = ~ioSel.opt2;

endmodule

// File: rtl/mem_cs_decoder_chk.sv
module mem_cs_decoder_chk
  import cs_decode_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [23:0] addr,
  input logic        memStrobe,
  input logic        ioStrobe,
  input logic        regWr,
  input logic        wrData,
  input logic        ros1N,
  input logic        ros2N,
  input logic        ras1N,
  input logic        ras2N,
  input logic        ras3N,
  input logic        perSelN,
  input logic        opt1SelN,
  input logic        opt2SelN,
  input ctrlStrb_t   ctrlStrb
);

  logic [4:0] memLow;
  logic [2:0] ioLow;
  logic       ctrlWrite;
  logic       inPageWin;

  assign memLow    = ~{ros1N, ros2N, ras1N, ras2N, ras3N};
  assign ioLow     = ~{perSelN, opt1SelN, opt2SelN};
  assign ctrlWrite = ioStrobe && regWr && (addr == 24'h00FF9F);
  assign inPageWin = (addr >= 24'h008000) && (addr <= 24'h00F7FF);

  assert_mem_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(memLow));
  assert_io_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ioLow));
  assert_mem_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    !memStrobe |-> (memLow == 5'b0));
  assert_io_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ioStrobe |-> (ioLow == 3'b0));
  assert_ros2_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    !ros2N |-> (addr[23:19] == 5'b11001));
  assert_ras1_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ras1N |-> (addr[23:17] == 7'b0001110));
  assert_page_route_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memStrobe && inPageWin) |->
      (ctrlStrb.pageToRas3 ? (!ras3N && ras2N) : (!ras2N && ras3N)));
  assert_wr_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrite |=> (ctrlStrb.pageToRas3 == $past(wrData)));
  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrite |=> $stable(ctrlStrb.pageToRas3));

endmodule

bind mem_cs_decoder mem_cs_decoder_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .addr      (addr),
  .memStrobe (memStrobe),
  .ioStrobe  (ioStrobe),
  .regWr     (regWr),
  .wrData    (wrData),
  .ros1N     (ros1N),
  .ros2N     (ros2N),
  .ras1N     (ras1N),
  .ras2N     (ras2N),
  .ras3N     (ras3N),
  .perSelN   (perSelN),
  .opt1SelN  (opt1SelN),
  .opt2SelN  (opt2SelN),
  .ctrlStrb  (ctrlStrb)
);

// File: tb/mem_cs_decoder_tb.sv
`timescale 1ns/1ps
module mem_cs_decoder_tb;

  // expected vector bit order: ros1 ros2 ras1 ras2 ras3 per opt1 opt2 (active high)
  localparam logic [7:0] X_NONE = 8'h00;
  localparam logic [7:0] X_ROS1 = 8'h80;
  localparam logic [7:0] X_ROS2 = 8'h40;
  localparam logic [7:0] X_RAS1 = 8'h20;
  localparam logic [7:0] X_RAS2 = 8'h10;
  localparam logic [7:0] X_RAS3 = 8'h08;
  localparam logic [7:0] X_PER  = 8'h04;
  localparam logic [7:0] X_OPT1 = 8'h02;
  localparam logic [7:0] X_OPT2 = 8'h01;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [23:0] addr = '0;
  logic memStrobe = 1'b0;
  logic ioStrobe = 1'b0;
  logic regWr = 1'b0;
  logic wrData = 1'b0;
  logic bootBoard = 1'b0;
  logic ros1N, ros2N, ras1N, ras2N, ras3N, perSelN, opt1SelN, opt2SelN;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  mem_cs_decoder u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .memStrobe(memStrobe), .ioStrobe(ioStrobe),
    .regWr(regWr), .wrData(wrData), .bootBoard(bootBoard),
    .ros1N(ros1N), .ros2N(ros2N), .ras1N(ras1N), .ras2N(ras2N), .ras3N(ras3N),
    .perSelN(perSelN), .opt1SelN(opt1SelN), .opt2SelN(opt2SelN)
  );

  function automatic logic [7:0] gotSel();
    return ~{ros1N, ros2N, ras1N, ras2N, ras3N, perSelN, opt1SelN, opt2SelN};
  endfunction

  task automatic judge(input logic [7:0] exp, input string req, input logic [23:0] a);
    checks++;
    if (gotSel() !== exp) begin
      fails++;
      $display("FAIL %s addr=%06h actual=%08b expected=%08b", req, a, gotSel(), exp);
    end
  endtask

  task automatic probe(input logic [23:0] a, input logic m, input logic i,
                       input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a; memStrobe = m; ioStrobe = i; regWr = 1'b0;
    #1;
    judge(exp, req, a);
  endtask

  task automatic writeCtrl(input logic [23:0] a, input logic i, input logic d);
    @(negedge clk);
    addr = a; memStrobe = 1'b0; ioStrobe = i; regWr = 1'b1; wrData = d;
    @(posedge clk);
    @(negedge clk);
    regWr = 1'b0; ioStrobe = 1'b0; wrData = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; memStrobe = 1'b0; ioStrobe = 1'b0; regWr = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset();
    probe(24'hC00000, 1'b0, 1'b0, X_NONE, "R9 idle after reset");
    probe(24'h008000, 1'b1, 1'b0, X_RAS2, "R6 page window after reset");
  endtask

  task automatic testRom();
    probe(24'hBFFFFF, 1'b1, 1'b0, X_NONE, "R10 below rom");
    probe(24'hC00000, 1'b1, 1'b0, X_ROS1, "R1 rom1 low edge");
    probe(24'hC43210, 1'b1, 1'b0, X_ROS1, "R1 rom1 middle");
    probe(24'hC7FFFF, 1'b1, 1'b0, X_ROS1, "R1 rom1 high edge");
    probe(24'hC80000, 1'b1, 1'b0, X_ROS2, "R1 rom2 low edge");
    probe(24'hCFFFFF, 1'b1, 1'b0, X_ROS2, "R1 rom2 high edge");
    probe(24'hD00000, 1'b1, 1'b0, X_NONE, "R10 above rom");
    probe(24'hFFFFFF, 1'b1, 1'b0, X_NONE, "R10 top of map");
  endtask

  task automatic testRam();
    probe(24'h010000, 1'b1, 1'b0, X_NONE, "R10 gap above page 0");
    probe(24'h1BFFFF, 1'b1, 1'b0, X_NONE, "R10 below ram1");
    probe(24'h1C0000, 1'b1, 1'b0, X_RAS1, "R2 ram1 low edge");
    probe(24'h1DFFFF, 1'b1, 1'b0, X_RAS1, "R2 ram1 high edge");
    probe(24'h1E0000, 1'b1, 1'b0, X_RAS2, "R2 ram2 low edge");
    probe(24'h1FFFFF, 1'b1, 1'b0, X_RAS2, "R2 ram2 high edge");
    probe(24'h200000, 1'b1, 1'b0, X_RAS3, "R3 ram3 low edge");
    probe(24'h27FFFF, 1'b1, 1'b0, X_RAS3, "R3 ram3 high edge");
    probe(24'h280000, 1'b1, 1'b0, X_NONE, "R3 above fitted bank");
    probe(24'h3FFFFF, 1'b1, 1'b0, X_NONE, "R3 top of bank area");
    probe(24'h400000, 1'b1, 1'b0, X_NONE, "R10 unused area low");
    probe(24'hBFFFF0, 1'b1, 1'b0, X_NONE, "R10 unused area high");
  endtask

  task automatic testBoot();
    bootBoard = 1'b0;
    probe(24'h000000, 1'b1, 1'b0, X_ROS1, "R4 image low edge no board");
    probe(24'h007FFF, 1'b1, 1'b0, X_ROS1, "R4 image high edge no board");
    bootBoard = 1'b1;
    probe(24'h000000, 1'b1, 1'b0, X_NONE, "R4 image low edge board");
    probe(24'h007FFF, 1'b1, 1'b0, X_NONE, "R4 image high edge board");
    probe(24'hC00000, 1'b1, 1'b0, X_ROS1, "R4 rom1 unaffected by board");
    bootBoard = 1'b0;
  endtask

  task automatic testPage();
    probe(24'h008000, 1'b1, 1'b0, X_RAS2, "R5 page low edge bit0");
    probe(24'h00F7FF, 1'b1, 1'b0, X_RAS2, "R5 page high edge bit0");
    probe(24'h00F800, 1'b1, 1'b0, X_NONE, "R5 above page window");
    probe(24'h00FFFF, 1'b1, 1'b0, X_NONE, "R5 memory top of page 0");
    writeCtrl(24'h00FF9F, 1'b1, 1'b1);
    probe(24'h008000, 1'b1, 1'b0, X_RAS3, "R5 page low edge bit1");
    probe(24'h00C000, 1'b1, 1'b0, X_RAS3, "R5 page middle bit1");
    probe(24'h00F7FF, 1'b1, 1'b0, X_RAS3, "R5 page high edge bit1");
    probe(24'h1E0000, 1'b1, 1'b0, X_RAS2, "R5 ram2 own range bit1");
    probe(24'h00F800, 1'b1, 1'b0, X_NONE, "R5 above window bit1");
    writeCtrl(24'h00FF9F, 1'b1, 1'b0);
    probe(24'h008000, 1'b1, 1'b0, X_RAS2, "R7 write back to 0");
  endtask

  task automatic testWriteCycle();
    writeCtrl(24'h00FF9E, 1'b1, 1'b1);
    probe(24'h008000, 1'b1, 1'b0, X_RAS2, "R7 wrong address ignored");
    writeCtrl(24'h00FF9F, 1'b0, 1'b1);
    probe(24'h008000, 1'b1, 1'b0, X_RAS2, "R7 no io strobe ignored");
    // write and peripheral select in one cycle; mapping moves only afterwards
    @(negedge clk);
    addr = 24'h00FF9F; memStrobe = 1'b0; ioStrobe = 1'b1; regWr = 1'b1; wrData = 1'b1;
    #1;
    judge(X_PER, "R7 peripheral select during write", addr);
    @(posedge clk);
    @(negedge clk);
    regWr = 1'b0; ioStrobe = 1'b0; wrData = 1'b0;
    probe(24'h008000, 1'b1, 1'b0, X_RAS3, "R7 mapping after write");
  endtask

  task automatic testIo();
    probe(24'h00FF7F, 1'b0, 1'b1, X_NONE, "R8 below peripheral");
    probe(24'h00FF80, 1'b0, 1'b1, X_PER,  "R8 peripheral low edge");
    probe(24'h00FF9F, 1'b0, 1'b1, X_PER,  "R8 peripheral high edge");
    probe(24'h00FFA0, 1'b0, 1'b1, X_NONE, "R8 gap low edge");
    probe(24'h00FFBF, 1'b0, 1'b1, X_NONE, "R8 gap high edge");
    probe(24'h00FFC0, 1'b0, 1'b1, X_OPT1, "R8 option1 low edge");
    probe(24'h00FFCF, 1'b0, 1'b1, X_OPT1, "R8 option1 high edge");
    probe(24'h00FFD0, 1'b0, 1'b1, X_OPT2, "R8 option2 low edge");
    probe(24'h00FFDF, 1'b0, 1'b1, X_OPT2, "R8 option2 high edge");
    probe(24'h00FFE0, 1'b0, 1'b1, X_NONE, "R8 above option2");
    probe(24'h00FFFF, 1'b0, 1'b1, X_NONE, "R8 top of io area");
  endtask

  task automatic testStrobes();
    probe(24'hC00000, 1'b0, 1'b0, X_NONE, "R9 rom without strobe");
    probe(24'h1C0000, 1'b0, 1'b1, X_NONE, "R9 ram with io strobe only");
    probe(24'h00FF80, 1'b1, 1'b0, X_NONE, "R9 io address with memory strobe");
    probe(24'h008000, 1'b1, 1'b1, X_RAS3, "R11 page window, both strobes");
  endtask

  task automatic testResetClears();
    doReset();
    probe(24'h008000, 1'b1, 1'b0, X_RAS2, "R6 reset clears page bit");
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired, actual=running expected=done");
    finish();
  end

  initial begin
    testReset();
    testRom();
    testRam();
    testBoot();
    testPage();
    testWriteCycle();
    testIo();
    testStrobes();
    testResetClears();
    finish();
  end

endmodule